// File: doc/BRIEF.md
# Binary Cubing Unit

This block raises an unsigned operand of parameterised width N to the third power and returns the full 3N-bit result. The work is done in two arithmetic steps. A duplex squarer forms the 2N-bit square by column pairs: each output column adds twice every symmetric bit pair and, on even columns, the lone middle bit. A vertical-and-crosswise column multiplier then multiplies that square by the original operand. It adds the bit products of each result column and sums the weighted columns.

Operands enter and cubes leave over valid/ready streams. On either side a word moves on a clock edge where valid and ready are both high. A producer holding valid high must keep its data unchanged until the word is taken. The parameter `OUT_REG` picks the output form. With 0 the unit is purely combinational: valid and ready pass straight through, and the cube appears in the same cycle. With 1 there is one register slot. It accepts a new operand whenever it is empty or its current word is leaving in the same cycle. It holds its word steady while the consumer stalls.

Top module: `cube_unit`

## Requirements
- R1: For every operand value, `out_cube` equals the operand cubed as an unsigned 3N-bit number, for N=4 and for N=8.
- R2: An operand of zero yields a cube of zero.
- R3: An all-ones operand yields (2^N-1)^3 with no bit lost (3375 for N=4, 16581375 for N=8).
- R4: Operand 1001b yields 1011011001b (decimal 729); the square of that operand inside the unit is 01010001b (decimal 81).
- R5: The squarer output always equals the operand times itself in 2N bits; powers of two cube to a single set bit at three times the exponent.
- R6: The column multiplier output always equals the 2N-bit square times the N-bit operand in 3N bits.
- R7: With OUT_REG=0, `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle, and `out_cube` is the cube of the present operand.
- R8: With OUT_REG=1, an operand accepted at an edge gives `out_valid` high with its cube after that edge; `in_ready` is high when the slot is empty or `out_ready` is high.
- R9: With OUT_REG=1, while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_cube` stays unchanged at the next edge.
- R10: With OUT_REG=1, `out_valid` is low after reset (`rst_n` low, active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Unit can take an operand |
| in_operand | input | N | Unsigned operand |
| out_valid | output | 1 | Cube word present |
| out_ready | input | 1 | Consumer can take the cube |
| out_cube | output | 3N | Unsigned cube of the operand |

## Verification
The bench builds two copies side by side. One has N=8 with the output register, so all 256 operands pass through the registered slot, and the stall, refill and reset behaviour of the stream can be reached. The other has N=4 and is purely combinational, so all 16 operands and the same-cycle pass-through of valid and ready are checked. Together the two copies cover both target widths exhaustively, including zero, all-ones and the 1001b example, at the extremes of the column sums.

// File: rtl/cube_pkg.sv
package cube_pkg;
  // bits needed to hold a count of 0..terms
  function automatic int unsigned count_bits(input int unsigned terms);
    return (terms < 1) ? 1 : $clog2(terms + 1);
  endfunction
endpackage

// File: rtl/duplex_squarer.sv
module duplex_squarer #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   a,
  output logic [2*N-1:0] sq
);
  import cube_pkg::*;
  localparam int unsigned SW   = 2 * N;
  localparam int unsigned COLS = 2 * N - 1;
  localparam int unsigned DW   = count_bits(N + 1);

  logic [COLS*DW-1:0] duplex_flat;

  for (genvar k = 0; k < COLS; k++) begin : g_col
    logic [DW-1:0] dval;
    always_comb begin
      dval = '0;
      for (int i = 0; i < N; i++) begin
        for (int j = i + 1; j < N; j++) begin
          if (i + j == k) dval = dval + DW'(2 * (a[i] & a[j]));
        end
      end
      if ((k % 2) == 0) dval = dval + DW'(a[k/2]);
    end
    assign duplex_flat[k*DW +: DW] = dval;
  end

  always_comb begin
    sq = '0;
    for (int k = 0; k < COLS; k++) begin
      sq = sq + (SW'(duplex_flat[k*DW +: DW]) << k);
    end
  end

  always_comb begin
    if (!$isunknown(a)) begin
      // R5
      square_exact_chk: assert (sq == {{N{1'b0}}, a} * {{N{1'b0}}, a});
    end
  end
endmodule

// File: rtl/column_multiplier.sv
module column_multiplier #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);
  import cube_pkg::*;
  localparam int unsigned PW   = AW + BW;
  localparam int unsigned COLS = AW + BW - 1;
  localparam int unsigned CW   = count_bits((AW < BW) ? AW : BW);

  logic [COLS*CW-1:0] col_flat;

  for (genvar k = 0; k < COLS; k++) begin : g_col
    logic [CW-1:0] csum;
    always_comb begin
      csum = '0;
      for (int i = 0; i < AW; i++) begin
        if ((k - i >= 0) && (k - i < BW)) csum = csum + CW'(a[i] & b[k-i]);
      end
    end
    assign col_flat[k*CW +: CW] = csum;
  end

  always_comb begin
    p = '0;
    for (int k = 0; k < COLS; k++) begin
      p = p + (PW'(col_flat[k*CW +: CW]) << k);
    end
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R6
      product_exact_chk: assert (p == PW'(a) * PW'(b));
    end
  end
endmodule

// File: rtl/cube_unit.sv
module cube_unit #(
  parameter int unsigned N       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_operand,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [3*N-1:0] out_cube
);
  localparam int unsigned SW = 2 * N;
  localparam int unsigned CW = 3 * N;
  localparam logic [CW-1:0] TOP_CUBE =
    CW'({N{1'b1}}) * CW'({N{1'b1}}) * CW'({N{1'b1}});

  logic [SW-1:0] square_w;
  logic [CW-1:0] cube_w;

  duplex_squarer #(.N(N)) u_sq (
    .a  (in_operand),
    .sq (square_w)
  );

  column_multiplier #(.AW(SW), .BW(N)) u_mul (
    .a (square_w),
    .b (in_operand),
    .p (cube_w)
  );

  if (OUT_REG) begin : g_reg
    logic          slot_v;
    logic [CW-1:0] slot_d;
    logic          take;

    assign in_ready  = !slot_v || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = slot_v;
    assign out_cube  = slot_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slot_v <= 1'b0;
      else if (take)      slot_v <= 1'b1;
      else if (out_ready) slot_v <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take) slot_d <= cube_w;
    end

    // R8
    fill_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_cube)));

    // R10
    empty_after_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> !out_valid);

    // R8
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_cube  = cube_w;

    // R3
    top_cube_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_operand == {N{1'b1}})) |-> (out_cube == TOP_CUBE));

    // R2
    zero_cube_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_operand == '0)) |-> (out_cube == '0));
  end
endmodule

// File: tb/tb_cube_unit.sv
module tb_cube_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // N=8, registered
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_operand = '0;
  logic        in_ready, out_valid;
  logic [23:0] out_cube;

  // N=4, combinational
  logic        c_in_valid = 1'b0, c_out_ready = 1'b0;
  logic [3:0]  c_operand = '0;
  logic        c_in_ready, c_out_valid;
  logic [11:0] c_cube;

  int n_checks = 0;
  int n_fail   = 0;

  cube_unit #(.N(8), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .out_valid(out_valid), .out_ready(out_ready),
    .out_cube(out_cube));

  cube_unit #(.N(4), .OUT_REG(1'b0)) dut_n4 (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .in_operand(c_operand), .out_valid(c_out_valid), .out_ready(c_out_ready),
    .out_cube(c_cube));

  function automatic longint ref_cube(input longint v);
    return v * v * v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one registered transfer, result sampled after the capturing edge
  task automatic push8(input int op, input string req);
    @(negedge clk);
    in_operand = 8'(op); in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, longint'(out_valid), 1);
    check(req, longint'(out_cube), ref_cube(op));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 valid low in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid low after reset", longint'(out_valid), 0);
    check("R8 ready while empty", longint'(in_ready), 1);
  endtask

  task automatic t_sweep8();
    for (int v = 0; v < 256; v++) push8(v, "R1 n8 sweep");
  endtask

  task automatic t_sweep4();
    c_in_valid = 1'b1; c_out_ready = 1'b1;
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      c_operand = 4'(v);
      #1;
      check("R1 n4 sweep", longint'(c_cube), ref_cube(v));
    end
  endtask

  task automatic t_corners();
    push8(0, "R2 n8 zero");
    push8(255, "R3 n8 all ones");
    check("R3 n8 value 16581375", longint'(out_cube), 16581375);
    push8(9, "R4 n8 1001b");
    check("R4 n8 729", longint'(out_cube), 729);
    for (int e = 0; e < 8; e++) begin
      push8(1 << e, "R5 power of two");
      check("R5 single bit", longint'(out_cube), longint'(1) << (3 * e));
    end
    push8(200, "R6 mixed");
    push8(170, "R6 alternating");
    @(negedge clk);
    c_operand = 4'd0; #1;
    check("R2 n4 zero", longint'(c_cube), 0);
    c_operand = 4'd15; #1;
    check("R3 n4 all ones", longint'(c_cube), 3375);
    c_operand = 4'b1001; #1;
    check("R4 n4 1001b", longint'(c_cube), 12'b001011011001);
  endtask

  task automatic t_passthrough();
    @(negedge clk);
    c_operand = 4'd5;
    c_in_valid = 1'b1; c_out_ready = 1'b0; #1;
    check("R7 valid follows", longint'(c_out_valid), 1);
    check("R7 ready follows low", longint'(c_in_ready), 0);
    check("R7 same-cycle cube", longint'(c_cube), 125);
    c_in_valid = 1'b0; c_out_ready = 1'b1; #1;
    check("R7 valid follows low", longint'(c_out_valid), 0);
    check("R7 ready follows high", longint'(c_in_ready), 1);
  endtask

  task automatic t_stall();
    @(negedge clk);
    in_operand = 8'd5; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R8 fill", longint'(out_valid), 1);
    check("R8 fill cube", longint'(out_cube), 125);
    check("R8 not ready while full and stalled", longint'(in_ready), 0);
    in_operand = 8'd7;
    @(negedge clk);
    check("R9 hold valid", longint'(out_valid), 1);
    check("R9 hold cube", longint'(out_cube), 125);
    out_ready = 1'b1; #1;
    check("R8 ready when draining", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 refill cube", longint'(out_cube), 343);
    @(negedge clk);
    check("R8 drained", longint'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_passthrough();
    t_sweep4();
    t_sweep8();
    t_corners();
    t_stall();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule